// File: doc/BRIEF.md
# Nine-bit word byte packer

This block turns a stream of tagged nine-bit words into a gap-free byte stream for a serial master that can only shift whole bytes. Each word carries a command/data flag and an eight-bit value. The words are laid end to end as one bit sequence, and a byte leaves the block as soon as its eight bits are present.

A frame is closed by an end-of-frame marker on its last word. The bit sequence of a frame seldom ends on a byte boundary. To close the frame, the block adds whole command-tagged filler words until the sequence does end on one. Because the filler opcode is one the display ignores, the receiver never sees a partial word. The final byte of each frame carries a last flag. The next frame then starts cleanly at the top of a fresh byte.

Both sides use valid/ready handshakes.

Top module: `ninebit_byte_packer`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: Each word enters the bit sequence flag first, then the value from its most significant bit down. A flag of 1 marks data and 0 marks a command.
- R3: The sequence fills each output byte from bit 7 down to bit 0 and then carries on into the next byte with no gap. A byte is offered as soon as it is complete.
- R4: When a frame of N words ends and N mod 8 is not 0, exactly 8 - (N mod 8) filler words are appended. Each filler word has flag 0 and value FILL_OP (default 0x5C).
- R5: A frame whose word count is a multiple of 8 gets no filler words.
- R6: A frame yields exactly 9*ceil(N/8) bytes. out_last is 1 on the final byte of the frame and 0 on every other byte.
- R7: The first word of every frame starts at bit 7 of a new byte.
- R8: in_ready is 0 while filler words are still owed for a closed frame and while a complete byte is waiting at the output.
- R9: While out_valid is 1 and out_ready is 0, the next cycle still has out_valid 1 with out_byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | A word is taken on this edge if in_valid is 1 |
| in_is_data | input | 1 | Word flag: 1 data, 0 command |
| in_val | input | VAL_W | Word value |
| in_eof | input | 1 | Word is the last of its frame |
| out_valid | output | 1 | A complete byte is offered |
| out_ready | input | 1 | Sink takes the byte on this edge |
| out_byte | output | BYTE_W | Packed byte, first bit in the MSB |
| out_last | output | 1 | Byte is the final one of its frame |

## Verification
The bench sweeps every frame length from 1 to 17 words, so every residue mod 8 occurs. That covers every filler count from 0 to 7, as well as the aligned lengths 8 and 16. A design that pads with zero bits, or that gets the filler count wrong, produces a byte stream and byte count that differ from the ones computed in the bench. Frames run back to back, so an alignment position carried over from one frame into the next shows up in the next frame's first byte. Three sink stall patterns test byte hold and input back-pressure. They catch a byte that changes while stalled, and words taken during padding.

// File: rtl/npk_pkg.sv
package npk_pkg;
    localparam int unsigned NPK_VAL_W_DEF  = 8;
    localparam int unsigned NPK_BYTE_W_DEF = 8;
    localparam logic [7:0]  NPK_FILL_DEF   = 8'h5C;

    typedef enum logic {
        PH_STREAM = 1'b0,
        PH_PAD    = 1'b1
    } npk_phase_e;
endpackage

// File: rtl/npk_bitbuf.sv
module npk_bitbuf #(
    parameter int WORD_W = 9,
    parameter int BYTE_W = 8,
    localparam int BUF_W = WORD_W + BYTE_W - 1,
    localparam int CNT_W = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [CNT_W-1:0]  cnt,
    output logic [BYTE_W-1:0] top_byte
);
    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [BUF_W-1:0] word_al;

    always_comb begin
        buf_d   = buf_q;
        word_al = {push_word, {(BYTE_W-1){1'b0}}};
        if (pop) begin
            buf_d.bits = buf_q.bits << BYTE_W;
            buf_d.cnt  = buf_q.cnt - CNT_W'(BYTE_W);
        end else if (push) begin
            buf_d.bits = buf_q.bits | (word_al >> buf_q.cnt);
            buf_d.cnt  = buf_q.cnt + CNT_W'(WORD_W);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign cnt      = buf_q.cnt;
    assign top_byte = buf_q.bits[BUF_W-1 -: BYTE_W];

    // R3: a word is appended only when it fits behind the pending bits
    a_r3_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CNT_W'(BYTE_W)));
    // R3: a byte is removed only when it is complete
    a_r3_pop_full: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt >= CNT_W'(BYTE_W)));
    // R3: the bit count never exceeds the storage
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BUF_W));
endmodule

// File: rtl/npk_frame_ctl.sv
module npk_frame_ctl #(
    parameter int VAL_W  = 8,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 5,
    parameter logic [VAL_W-1:0] FILL_OP = VAL_W'(8'h5C),
    localparam int WORD_W = VAL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_is_data,
    input  logic [VAL_W-1:0]  in_val,
    input  logic              in_eof,
    input  logic              out_ready,
    input  logic [CNT_W-1:0]  cnt,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_last,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              pop
);
    import npk_pkg::*;

    typedef struct packed {
        npk_phase_e phase;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic have_byte, pad_need, take;

    always_comb begin
        ctl_d     = ctl_q;
        have_byte = (cnt >= CNT_W'(BYTE_W));
        out_valid = have_byte;
        pop       = have_byte && out_ready;
        out_last  = (ctl_q.phase == PH_PAD) && (cnt == CNT_W'(BYTE_W));
        in_ready  = !have_byte && (ctl_q.phase == PH_STREAM);
        take      = in_valid && in_ready;
        pad_need  = (ctl_q.phase == PH_PAD) && !have_byte && (cnt != '0);
        push      = take || pad_need;
        push_word = pad_need ? {1'b0, FILL_OP} : {in_is_data, in_val};
        if (take && in_eof)  ctl_d.phase = PH_PAD;
        if (pop && out_last) ctl_d.phase = PH_STREAM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{phase: PH_STREAM};
        else        ctl_q <= ctl_d;
    end

    // R4: a filler word always brings a full byte into the buffer
    a_r4_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
        pad_need |=> (cnt >= CNT_W'(BYTE_W)));
    // R6/R7: the last byte leaves the buffer empty for the next frame
    a_r7_fresh_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && out_last) |=> (cnt == '0 && ctl_q.phase == PH_STREAM));
    // R8: no word is taken while padding is owed
    a_r8_no_take_in_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_PAD) |-> !(in_valid && in_ready));
endmodule

// File: rtl/ninebit_byte_packer.sv
module ninebit_byte_packer #(
    parameter int VAL_W  = npk_pkg::NPK_VAL_W_DEF,
    parameter int BYTE_W = npk_pkg::NPK_BYTE_W_DEF,
    parameter logic [VAL_W-1:0] FILL_OP = VAL_W'(npk_pkg::NPK_FILL_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_data,
    input  logic [VAL_W-1:0]  in_val,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last
);
    localparam int WORD_W = VAL_W + 1;
    localparam int BUF_W  = WORD_W + BYTE_W - 1;
    localparam int CNT_W  = $clog2(BUF_W + 1);

    logic              push, pop;
    logic [WORD_W-1:0] push_word;
    logic [CNT_W-1:0]  cnt;

    npk_frame_ctl #(
        .VAL_W(VAL_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .FILL_OP(FILL_OP)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_is_data(in_is_data), .in_val(in_val),
        .in_eof(in_eof), .out_ready(out_ready), .cnt(cnt),
        .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last),
        .push(push), .push_word(push_word), .pop(pop)
    );

    npk_bitbuf #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_word(push_word), .pop(pop),
        .cnt(cnt), .top_byte(out_byte)
    );

    // R9: a stalled byte is held unchanged
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
    // R8: input and output are never both open
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
    // R6: the last flag only rides on an offered byte
    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: tb/ninebit_byte_packer_tb.sv
module ninebit_byte_packer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_is_data = 1'b0, in_eof = 1'b0;
    logic [7:0] in_val = 8'h00;
    logic       in_ready, out_valid, out_ready, out_last;
    logic [7:0] out_byte;

    int  n_checks = 0, n_fail = 0, cyc = 0, rx_frame = 0;
    bit  timed_out = 1'b0, pad_open = 1'b0;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ninebit_byte_packer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_data(in_is_data), .in_val(in_val), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_last(out_last)
    );

    function automatic logic [8:0] word_of(input int f, input int i);
        logic [7:0] v;
        v = 8'((f * 37 + i * 11 + 3) & 255);
        return {((f + i) % 3) != 0, v};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected stream: words flag-first MSB-first (R2), packed from bit 7 (R3),
    // padded with {0,0x5C} up to a multiple of 8 words (R4, R5), last flag (R6).
    task automatic send_frame(input int f, input int n);
        logic [8:0]   w;
        logic [0:255] bits;
        logic [7:0]   by;
        int wp, nb;
        bit ok;
        bits = '0;
        wp = ((n + 7) / 8) * 8;
        for (int i = 0; i < wp; i++) begin
            w = (i < n) ? word_of(f, i) : {1'b0, 8'h5C};
            for (int b = 0; b < 9; b++) bits[i*9 + b] = w[8 - b];
        end
        nb = wp * 9 / 8;
        for (int k = 0; k < nb; k++) begin
            for (int b = 0; b < 8; b++) by[7 - b] = bits[k*8 + b];
            exp_q.push_back({(k == nb - 1), by});
        end
        for (int i = 0; i < n; i++) begin
            w = word_of(f, i);
            in_is_data = w[8];
            in_val     = w[7:0];
            in_eof     = (i == n - 1);
            in_valid   = 1'b1;
            do begin
                #1 ok = in_ready;
                @(posedge clk);
                if (ok && in_eof) pad_open = 1'b1;
                @(negedge clk);
            end while (!ok && !timed_out);
        end
        in_valid = 1'b0;
        in_eof   = 1'b0;
    endtask

    // Sink: stall patterns, output checks and back-pressure checks
    initial begin
        logic [8:0] e;
        logic [7:0] held;
        bit stalled;
        out_ready = 1'b0;
        stalled = 1'b0;
        held = 8'h00;
        wait (rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) timed_out = 1'b1;
            case (rx_frame % 3)
                0:       out_ready = 1'b1;
                1:       out_ready = cyc[0];
                default: out_ready = (cyc % 4) == 0;
            endcase
            #1;
            if (stalled)
                check(out_valid && out_byte == held, "R9 stalled byte held", int'(out_byte), int'(held));
            check(!(out_valid && in_ready), "R8 ready while byte waits", int'(in_ready), 0);
            if (pad_open)
                check(!in_ready, "R8 ready while padding owed", int'(in_ready), 0);
            stalled = out_valid && !out_ready;
            held    = out_byte;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 extra byte", int'(out_byte), 0);
                end else begin
                    e = exp_q.pop_front();
                    check(out_byte == e[7:0], "R2/R3/R4/R5/R7 byte value", int'(out_byte), int'(e[7:0]));
                    check(out_last == e[8], "R6 last flag", int'(out_last), int'(e[8]));
                    if (e[8]) begin
                        rx_frame++;
                        pad_open = 1'b0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(out_last == 1'b0, "R1 out_last after reset", int'(out_last), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        @(negedge clk);
        for (int rep = 0; rep < 2; rep++)
            for (int n = 1; n <= 17; n++)
                if (!timed_out) send_frame(rep * 17 + n, n);
        while (exp_q.size() != 0 && !timed_out) @(negedge clk);
        repeat (10) @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R6 no bytes beyond frame", int'(out_valid), 0);
        check(exp_q.size() == 0, "R6 byte count", exp_q.size(), 0);
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule